// File: doc/BRIEF.md
# Snoop Hold-and-Inquire Sequencer

This block sits on the system side of a processor bus. It runs a cache snoop on behalf of an external bus master. When the master asks for a snoop, the sequencer captures the line address and raises a bus hold request to the processor. It then waits until the processor's hold acknowledge is actually sampled. Only after that does it drive the address lines and give a single-clock inquire strobe. The acknowledge may arrive after any number of clocks, so a processor that grants later than usual, for example after a back-off collides with a hold request, is handled without address contention and without a lost strobe.

After the strobe, the sequencer stops driving the address so that the processor can own it again. It samples a dirty-hit indication on the second clock edge after the strobe edge. On a clean result it drops hold and signals completion at once. On a dirty hit it keeps hold asserted until the processor's writeback burst reports its last transfer, and only then drops hold and signals completion.

Top module: `snoop_hold_sequencer`

## Requirements
- R1: Out of reset, `bus_hold_req` is 0, `inq_strobe_n` is 1, `addr_oe` is 0 and `snoop_done` is 0.
- R2: A `snoop_req` sampled high while the sequencer is idle captures `snoop_addr`, and `bus_hold_req` is 1 from the following cycle.
- R3: While waiting for the grant, `inq_strobe_n` stays 1 and `addr_oe` stays 0. The grant counts only on an edge where `bus_hold_ack` is 1 and both `cpu_addr_strobe_n` and `cpu_backoff_n` are 1. No fixed grant latency is assumed.
- R4: In the cycle after the qualifying grant edge, `inq_strobe_n` is 0, `addr_oe` is 1 and `addr_out` equals the captured address (line address bits 31..3, `addr_out[0]` being bit 3).
- R5: In the next cycle, `inq_strobe_n` returns to 1 and `addr_oe` to 0 while `bus_hold_req` stays 1.
- R6: `snoop_dirty_n` is sampled on the second edge after the edge that ends the strobe cycle. If it is 1, the next cycle shows `bus_hold_req` = 0 and `snoop_done` = 1 for exactly one cycle.
- R7: If `snoop_dirty_n` is 0 on that edge, `bus_hold_req` stays 1 and `snoop_done` stays 0 until `wb_last` is sampled 1. The following cycle shows `bus_hold_req` = 0 and `snoop_done` = 1 for one cycle.
- R8: A `snoop_req` raised while a snoop is in progress is ignored: once the current snoop completes, hold does not rise again.
- R9: `snoop_dirty_n` has no effect on any edge other than the sampling edge of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snoop_req | input | 1 | Snoop request from the external master |
| snoop_addr | input | ADDR_W | Line address to snoop (bits 31..3) |
| snoop_done | output | 1 | One-cycle completion pulse to the master |
| bus_hold_req | output | 1 | Bus hold request to the processor |
| bus_hold_ack | input | 1 | Hold acknowledge from the processor |
| cpu_addr_strobe_n | input | 1 | Processor bus-cycle start strobe, active low |
| cpu_backoff_n | input | 1 | Back-off signal on the processor bus, active low |
| addr_out | output | ADDR_W | Inquire address toward the processor |
| addr_oe | output | 1 | Output enable for `addr_out` |
| inq_strobe_n | output | 1 | Inquire strobe, active low, one clock |
| snoop_dirty_n | input | 1 | Dirty-hit indication, active low |
| wb_last | input | 1 | Last transfer of the writeback burst |

## Verification
The bench goes after grants that arrive zero, one, two or several clocks late. It also covers an acknowledge that is high while back-off or the processor's address strobe is still low. A sequencer that assumed a fixed grant latency would strobe and drive the address into a bus the processor still owns. It drives a misleading dirty value on the edges around the real sampling edge; a design sampling one clock early or late would enter or skip the writeback wait wrongly. It varies the writeback length and raises a request in mid-snoop, so early hold release or a phantom second snoop show up as wrong hold or done values.

// File: rtl/snoop_hold_sequencer.sv
module snoop_hold_sequencer #(
  parameter int ADDR_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_req,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_done,
  output logic              bus_hold_req,
  input  logic              bus_hold_ack,
  input  logic              cpu_addr_strobe_n,
  input  logic              cpu_backoff_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_oe,
  output logic              inq_strobe_n,
  input  logic              snoop_dirty_n,
  input  logic              wb_last
);

  typedef enum logic [2:0] {
    S_IDLE, S_ASK, S_INQ, S_SNP1, S_SNP2, S_WB, S_FIN
  } seq_state_t;

  seq_state_t state, state_nx;
  logic [ADDR_W-1:0] addr_q;

  wire grant_seen = bus_hold_ack & cpu_addr_strobe_n & cpu_backoff_n;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (snoop_req) state_nx = S_ASK;
      S_ASK:  if (grant_seen) state_nx = S_INQ;
      S_INQ:  state_nx = S_SNP1;
      S_SNP1: state_nx = S_SNP2;
      S_SNP2: state_nx = snoop_dirty_n ? S_FIN : S_WB;
      S_WB:   if (wb_last) state_nx = S_FIN;
      S_FIN:  state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE && snoop_req) addr_q <= snoop_addr;
    end
  end

  assign bus_hold_req = (state != S_IDLE) && (state != S_FIN);
  assign inq_strobe_n = (state != S_INQ);
  assign addr_oe      = (state == S_INQ);
  assign addr_out     = addr_q;
  assign snoop_done   = (state == S_FIN);

endmodule

module snoop_hold_sequencer_chk #(
  parameter int ADDR_W = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_done,
  input logic              bus_hold_req,
  input logic              bus_hold_ack,
  input logic              cpu_addr_strobe_n,
  input logic              cpu_backoff_n,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_oe,
  input logic              inq_strobe_n
);

  AST_STROBE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !inq_strobe_n |-> ($past(bus_hold_ack) && $past(cpu_addr_strobe_n) && $past(cpu_backoff_n))); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inq_strobe_n |=> (inq_strobe_n && !addr_oe && bus_hold_req)); // R5

  AST_DRIVE_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> (bus_hold_req && !inq_strobe_n)); // R4

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_done |-> !bus_hold_req); // R6

  AST_HOLD_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_hold_req) |-> snoop_done); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hold_req && $past(bus_hold_req)) |-> $stable(addr_out)); // R8

endmodule

bind snoop_hold_sequencer snoop_hold_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snoop_done(snoop_done), .bus_hold_req(bus_hold_req),
  .bus_hold_ack(bus_hold_ack), .cpu_addr_strobe_n(cpu_addr_strobe_n),
  .cpu_backoff_n(cpu_backoff_n), .addr_out(addr_out), .addr_oe(addr_oe),
  .inq_strobe_n(inq_strobe_n)
);

// File: tb/snoop_hold_sequencer_bench.sv
module snoop_hold_sequencer_bench;
  localparam int AW = 29;

  logic clk = 0;
  logic rst_n = 0;
  logic snoop_req = 0;
  logic [AW-1:0] snoop_addr = '0;
  logic snoop_done, bus_hold_req, addr_oe, inq_strobe_n;
  logic [AW-1:0] addr_out;
  logic bus_hold_ack = 0, cpu_addr_strobe_n = 1, cpu_backoff_n = 1;
  logic snoop_dirty_n = 1, wb_last = 0;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  snoop_hold_sequencer #(.ADDR_W(AW)) u_snoop_hold_sequencer (
    .clk(clk), .rst_n(rst_n), .snoop_req(snoop_req), .snoop_addr(snoop_addr),
    .snoop_done(snoop_done), .bus_hold_req(bus_hold_req), .bus_hold_ack(bus_hold_ack),
    .cpu_addr_strobe_n(cpu_addr_strobe_n), .cpu_backoff_n(cpu_backoff_n),
    .addr_out(addr_out), .addr_oe(addr_oe), .inq_strobe_n(inq_strobe_n),
    .snoop_dirty_n(snoop_dirty_n), .wb_last(wb_last)
  );

  function automatic bit grant_ok(bit ack, bit ads_n, bit boff_n);
    return ack && ads_n && boff_n;
  endfunction

  function automatic bit exp_hold_after_sample(bit dirty);
    return dirty;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // mode: 0 random grant, 1 directed delay with backoff low at grant, 2 directed with addr strobe low at grant
  task automatic snoop(logic [AW-1:0] a, bit dirty, int wblen, int mode, int dly);
    int n = 0;
    bit g;
    @(negedge clk);
    snoop_req = 1; snoop_addr = a;
    bus_hold_ack = 0; cpu_addr_strobe_n = 1; cpu_backoff_n = 1;
    @(negedge clk);
    snoop_req = 0; snoop_addr = ~a;
    check(bus_hold_req == 1, "R2 hold after request", bus_hold_req, 1);
    while (1) begin
      if (mode == 0) begin
        if (n < 6) begin
          bus_hold_ack = $urandom_range(0, 1);
          cpu_addr_strobe_n = ($urandom_range(0, 3) != 0);
          cpu_backoff_n = ($urandom_range(0, 3) != 0);
        end else begin
          bus_hold_ack = 1; cpu_addr_strobe_n = 1; cpu_backoff_n = 1;
        end
      end else begin
        bus_hold_ack = (n >= dly);
        cpu_backoff_n = !(mode == 1 && n == dly);
        cpu_addr_strobe_n = !(mode == 2 && n == dly);
      end
      g = grant_ok(bus_hold_ack, cpu_addr_strobe_n, cpu_backoff_n);
      snoop_dirty_n = dirty;
      @(negedge clk);
      n++;
      if (g) break;
      check(inq_strobe_n == 1 && addr_oe == 0 && bus_hold_req == 1,
            "R3 no strobe before grant", {inq_strobe_n, addr_oe, bus_hold_req}, 3'b101);
    end
    check(inq_strobe_n == 0 && addr_oe == 1, "R4 strobe and drive", {inq_strobe_n, addr_oe}, 2'b01);
    check(addr_out == a, "R4 inquire address", addr_out, a);
    snoop_dirty_n = dirty;
    @(negedge clk);
    check(inq_strobe_n == 1 && addr_oe == 0 && bus_hold_req == 1,
          "R5 strobe released", {inq_strobe_n, addr_oe, bus_hold_req}, 3'b101);
    snoop_dirty_n = dirty;
    snoop_req = 1; snoop_addr = a ^ 29'h5;
    @(negedge clk);
    snoop_req = 0;
    check(bus_hold_req == 1 && snoop_done == 0, "R9 hold before sample", {bus_hold_req, snoop_done}, 2'b10);
    snoop_dirty_n = !dirty;
    @(negedge clk);
    snoop_dirty_n = 1;
    if (dirty) begin
      for (int i = 0; i < wblen; i++) begin
        check(bus_hold_req == exp_hold_after_sample(dirty) && snoop_done == 0,
              "R7 hold during writeback", {bus_hold_req, snoop_done}, 2'b10);
        wb_last = (i == wblen - 1);
        @(negedge clk);
        wb_last = 0;
      end
      check(bus_hold_req == 0 && snoop_done == 1, "R7 release after last", {bus_hold_req, snoop_done}, 2'b01);
    end else begin
      check(bus_hold_req == 0 && snoop_done == 1, "R6 clean release", {bus_hold_req, snoop_done}, 2'b01);
    end
    @(negedge clk);
    check(bus_hold_req == 0 && snoop_done == 0, "R8 no phantom snoop", {bus_hold_req, snoop_done}, 2'b00);
    bus_hold_ack = 0;
    @(negedge clk);
    check(bus_hold_req == 0 && snoop_done == 0, "R8 still idle", {bus_hold_req, snoop_done}, 2'b00);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #5;
    check(bus_hold_req == 0 && inq_strobe_n == 1 && addr_oe == 0 && snoop_done == 0,
          "R1 reset state", {bus_hold_req, inq_strobe_n, addr_oe, snoop_done}, 4'b0100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(bus_hold_req == 0 && inq_strobe_n == 1, "R1 idle after reset", {bus_hold_req, inq_strobe_n}, 2'b01);

    snoop(29'h1ABC_DEF0, 0, 1, 1, 0);
    snoop(29'h0000_0001, 0, 1, 1, 1);
    snoop(29'h1FFF_FFFF, 1, 1, 1, 2);
    snoop(29'h0F0F_0F0F, 1, 4, 2, 2);
    snoop(29'h0000_0000, 1, 2, 2, 5);

    for (int k = 0; k < 40; k++)
      snoop($urandom, $urandom_range(0, 1), $urandom_range(1, 5), 0, 0);

    finish_run();
  end
endmodule